// File: doc/BRIEF.md
# Multi-queue inter-processor mailbox

This block lets several processors exchange 32-bit messages through a bank of independent one-way queues. Each queue is a small first-in-first-out store built from flip-flops. A sender pushes a word by writing the queue's data register, and the receiver pops it by reading the same register. A per-queue status register shows whether the queue is empty or full, how many messages it holds, and two sticky error bits. A per-queue configuration register routes the queue's arrival interrupt to any subset of the user interrupt lines and selects a level or an edge trigger.

Several bus masters share one register port. A fixed-priority arbiter grants one access per cycle, and the lowest-numbered requester wins. A master that loses keeps its request asserted until it is granted. The grant is combinational in the request cycle. The queue, status and configuration state changes at the following clock edge. Read data comes back one cycle after the grant, flagged by a valid strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty with count 0, the sticky bits are clear, every configuration register reads 0, and `irq_o` and `rvalid_o` are low.
- R2: Each queue holds up to 4 words of 32 bits and returns them in the order they were written.
- R3: A status read returns bit 0 = empty, bit 1 = full and bits [10:8] = the current message count. All other bits read 0 except the sticky bits of R4 and R5.
- R4: A write to a full queue is discarded, leaves the stored words unchanged and sets sticky overflow bit 2 of the status.
- R5: A data read from an empty queue returns 0 and sets sticky underflow bit 3 of the status.
- R6: Writing the status register with bit 2 or bit 3 set clears the matching sticky bit. A 0 in that bit leaves it unchanged.
- R7: Address bits [5:2] select the queue and bits [1:0] select the register: 0 = data, 1 = status, 2 = configuration. Configuration bits [3:0] enable user lines 3..0 and bit 4 selects edge mode. The configuration register reads back what was written. A granted read raises `rvalid_o` with its data exactly one cycle after the grant, and `rvalid_o` is low otherwise.
- R8: In level mode, an enabled user line is high while the queue holds at least one message.
- R9: In edge mode, an enabled user line pulses for exactly one cycle, in the cycle after a write takes the queue from empty to non-empty. A write to a queue that already holds a message gives no pulse.
- R10: At most one master is granted per cycle. The grant goes to the lowest-numbered requester, and some requester is always granted.
- R11: Each user line is the OR of the contributions of all queues routed to it, and a queue with no enable bits set never drives a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Access request per master, held until granted |
| we_i | input | N_MST | Write (1) or read (0) per master |
| addr_i | input | N_MST*6 | Word address per master, master m at [m*6 +: 6] |
| wdata_i | input | N_MST*32 | Write data per master, master m at [m*32 +: 32] |
| gnt_o | output | N_MST | One-hot grant, same cycle as the request |
| rvalid_o | output | 1 | Read data valid, one cycle after a read grant |
| rdata_o | output | 32 | Read data |
| irq_o | output | N_USR | User interrupt lines |

## Verification
A grant is due in the same cycle as the request. The bench therefore drives requests at the falling edge and samples `gnt_o` shortly after it. Queue contents, status, configuration and level interrupts change at the rising edge that ends the granted cycle, and read data is due at that same edge. The bench samples all of these at the next falling edge. An edge interrupt is high only during the cycle that follows that rising edge, so the bench checks it at that falling edge and confirms it low one falling edge later. The sweeps cover every queue for fill, overflow, drain, underflow and clearing, and every queue and user pair in both trigger modes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CFG  = 2'd2,
    REG_RSVD = 2'd3
  } mbx_reg_e;

  localparam int STAT_EMPTY = 0;
  localparam int STAT_FULL  = 1;
  localparam int STAT_OVF   = 2;
  localparam int STAT_UDF   = 3;
  localparam int STAT_CNT   = 8;
  localparam int CFG_EDGE   = 4;
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // isolate lowest set request bit
  assign gnt_o = req_i & (~req_i + N'(1));
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              clr_ovf_i,
  input  logic              clr_udf_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] head_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr];
  assign cnt_o   = cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf_o  <= 1'b0;
      udf_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push) cnt <= cnt + CNT_W'(1);
      else if (do_pop) cnt <= cnt - CNT_W'(1);
      if (push_i & full_o) ovf_o <= 1'b1;
      else if (clr_ovf_i)  ovf_o <= 1'b0;
      if (pop_i & empty_o) udf_o <= 1'b1;
      else if (clr_udf_i)  udf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int N_Q   = 16,
  parameter int N_USR = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_Q-1:0]            ne_i,
  input  logic [N_Q-1:0][N_USR-1:0] en_i,
  input  logic [N_Q-1:0]            edge_i,
  output logic [N_USR-1:0]          irq_o
);
  logic [N_Q-1:0] prev_ne, src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_ne <= '0;
    else         prev_ne <= ne_i;
  end

  // edge: one cycle on empty -> non-empty; level: while non-empty
  assign src = (edge_i & ne_i & ~prev_ne) | (~edge_i & ne_i);

  always_comb begin
    irq_o = '0;
    for (int u = 0; u < N_USR; u++)
      for (int q = 0; q < N_Q; q++)
        irq_o[u] = irq_o[u] | (src[q] & en_i[q][u]);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int N_MST  = 3,
  parameter int N_Q    = 16,
  parameter int N_USR  = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST-1:0]        we_i,
  input  logic [N_MST*($clog2(N_Q)+2)-1:0] addr_i,
  input  logic [N_MST*DATA_W-1:0] wdata_i,
  output logic [N_MST-1:0]        gnt_o,
  output logic                    rvalid_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [N_USR-1:0]        irq_o
);
  import mbx_pkg::*;

  localparam int QIDX_W = $clog2(N_Q);
  localparam int ADDR_W = QIDX_W + 2;
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic              win_valid, win_we;
  logic [ADDR_W-1:0] win_addr;
  logic [DATA_W-1:0] win_wdata;
  logic [QIDX_W-1:0] acc_q;
  mbx_reg_e          acc_reg;

  mbx_arbiter #(.N(N_MST)) u_arb (.req_i(req_i), .gnt_o(gnt_o));

  always_comb begin
    win_we    = 1'b0;
    win_addr  = '0;
    win_wdata = '0;
    for (int m = 0; m < N_MST; m++) begin
      if (gnt_o[m]) begin
        win_we    = we_i[m];
        win_addr  = addr_i[m*ADDR_W +: ADDR_W];
        win_wdata = wdata_i[m*DATA_W +: DATA_W];
      end
    end
  end

  assign win_valid = |gnt_o;
  assign acc_q     = win_addr[ADDR_W-1:2];
  assign acc_reg   = mbx_reg_e'(win_addr[1:0]);

  logic [N_Q-1:0]            q_empty, q_full, q_ovf, q_udf, q_edge;
  logic [N_Q-1:0][N_USR-1:0] q_en;
  logic [CNT_W-1:0]          q_cnt  [N_Q];
  logic [DATA_W-1:0]         q_head [N_Q];

  for (genvar q = 0; q < N_Q; q++) begin : g_q
    logic hit, st_wr;
    assign hit   = win_valid && (acc_q == QIDX_W'(q));
    assign st_wr = hit && win_we && (acc_reg == REG_STAT);

    mbx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (hit && win_we && (acc_reg == REG_DATA)),
      .pop_i    (hit && !win_we && (acc_reg == REG_DATA)),
      .clr_ovf_i(st_wr && win_wdata[STAT_OVF]),
      .clr_udf_i(st_wr && win_wdata[STAT_UDF]),
      .wdata_i  (win_wdata),
      .head_o   (q_head[q]),
      .cnt_o    (q_cnt[q]),
      .empty_o  (q_empty[q]),
      .full_o   (q_full[q]),
      .ovf_o    (q_ovf[q]),
      .udf_o    (q_udf[q])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_en[q]   <= '0;
        q_edge[q] <= 1'b0;
      end else if (hit && win_we && (acc_reg == REG_CFG)) begin
        q_en[q]   <= win_wdata[N_USR-1:0];
        q_edge[q] <= win_wdata[CFG_EDGE];
      end
    end
  end

  mbx_irq #(.N_Q(N_Q), .N_USR(N_USR)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ne_i  (~q_empty),
    .en_i  (q_en),
    .edge_i(q_edge),
    .irq_o (irq_o)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (acc_reg)
      REG_DATA: rd_mux = q_empty[acc_q] ? '0 : q_head[acc_q];
      REG_STAT: begin
        rd_mux[STAT_EMPTY]          = q_empty[acc_q];
        rd_mux[STAT_FULL]           = q_full[acc_q];
        rd_mux[STAT_OVF]            = q_ovf[acc_q];
        rd_mux[STAT_UDF]            = q_udf[acc_q];
        rd_mux[STAT_CNT +: CNT_W]   = q_cnt[acc_q];
      end
      REG_CFG: begin
        rd_mux[N_USR-1:0] = q_en[acc_q];
        rd_mux[CFG_EDGE]  = q_edge[acc_q];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= win_valid & ~win_we;
      if (win_valid & ~win_we) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int N_MST = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic [N_MST-1:0] we_i,
  input logic [N_MST-1:0] gnt_o,
  input logic             rvalid_o
);
  logic rd_win;
  assign rd_win = |(gnt_o & ~we_i);

  // R10
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R10
  gnt_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  // R10
  gnt_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> ((req_i & (gnt_o - N_MST'(1))) == '0));

  // R10
  gnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));

  // R7
  rvalid_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_win |=> rvalid_o);

  // R7
  rvalid_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_win |=> !rvalid_o);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.N_MST(N_MST)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .gnt_o   (gnt_o),
  .rvalid_o(rvalid_o)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  localparam int NM = 3;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] req = '0;
  logic [NM-1:0] we = '0;
  logic [NM*AW-1:0] addr = '0;
  logic [NM*32-1:0] wdata = '0;
  logic [NM-1:0] gnt;
  logic          rvalid;
  logic [31:0]   rdata;
  logic [3:0]    irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipc_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ad(input int q, input int r);
    return {q[3:0], r[1:0]};
  endfunction

  // one access from master m; returns at the falling edge after the granted cycle
  task automatic acc(input int m, input bit w, input logic [5:0] a,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req[m] = 1'b1; we[m] = w;
    addr[m*AW +: AW] = a; wdata[m*32 +: 32] = d;
    #1;
    while (!gnt[m]) begin @(negedge clk); #1; end
    @(negedge clk);
    req[m] = 1'b0;
    rd = rdata;
    if (!w) chk("R7 rvalid after read", {31'd0, rvalid}, 32'd1);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] x;
    acc(0, 1'b1, a, d, x);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] x;
    acc(0, 1'b0, a, 32'd0, x);
    chk(tag, x, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq after reset", {28'd0, irq}, 32'd0);
    chk("R1 rvalid after reset", {31'd0, rvalid}, 32'd0);
    for (int q = 0; q < 16; q++) begin
      rd_chk("R1 status after reset", ad(q, 1), 32'h1);
      rd_chk("R1 config after reset", ad(q, 2), 32'h0);
    end

    // R2 R3 R4 R5 R6 sweep over all queues
    for (int q = 0; q < 16; q++) begin
      for (int k = 0; k < 4; k++) begin
        wr(ad(q, 0), 32'hA500_0000 + q * 256 + k);
        rd_chk("R3 count while filling", ad(q, 1),
               ((k + 1) << 8) | ((k == 3) ? 32'h2 : 32'h0));
      end
      wr(ad(q, 0), 32'hDEAD_0000 + q);
      rd_chk("R4 overflow on full", ad(q, 1), 32'h406);
      for (int k = 0; k < 4; k++)
        rd_chk("R2 fifo order", ad(q, 0), 32'hA500_0000 + q * 256 + k);
      rd_chk("R3 empty after drain", ad(q, 1), 32'h5);
      rd_chk("R5 empty read zero", ad(q, 0), 32'h0);
      rd_chk("R5 underflow sticky", ad(q, 1), 32'hD);
      wr(ad(q, 1), 32'h0);
      rd_chk("R6 zero write keeps sticky", ad(q, 1), 32'hD);
      wr(ad(q, 1), 32'h4);
      rd_chk("R6 clear overflow only", ad(q, 1), 32'h9);
      wr(ad(q, 1), 32'h8);
      rd_chk("R6 clear underflow", ad(q, 1), 32'h1);
      wr(ad(q, 2), 32'h15 ^ q);
      rd_chk("R7 config readback", ad(q, 2), (32'h15 ^ q) & 32'h1F);
      wr(ad(q, 2), 32'h0);
    end

    // R8 R9 per queue and user
    for (int q = 0; q < 16; q++) begin
      for (int u = 0; u < 4; u++) begin
        wr(ad(q, 2), 32'h1 << u);
        wr(ad(q, 0), 32'h100 + u);
        chk("R8 level high", {28'd0, irq}, 32'h1 << u);
        @(negedge clk);
        chk("R8 level holds", {28'd0, irq}, 32'h1 << u);
        rd_chk("R2 single word", ad(q, 0), 32'h100 + u);
        chk("R8 level low when empty", {28'd0, irq}, 32'h0);
        wr(ad(q, 2), 32'h10 | (32'h1 << u));
        wr(ad(q, 0), 32'h200 + u);
        chk("R9 edge pulse", {28'd0, irq}, 32'h1 << u);
        @(negedge clk);
        chk("R9 pulse one cycle", {28'd0, irq}, 32'h0);
        wr(ad(q, 0), 32'h300 + u);
        chk("R9 no pulse when non-empty", {28'd0, irq}, 32'h0);
        rd_chk("R2 edge word a", ad(q, 0), 32'h200 + u);
        rd_chk("R2 edge word b", ad(q, 0), 32'h300 + u);
        wr(ad(q, 2), 32'h0);
      end
    end

    // R11 disabled queue and OR of queues
    wr(ad(7, 0), 32'h77);
    chk("R11 disabled queue silent", {28'd0, irq}, 32'h0);
    wr(ad(3, 2), 32'h4);
    wr(ad(9, 2), 32'h4);
    chk("R11 routed queue pending", {28'd0, irq}, 32'h0);
    wr(ad(7, 2), 32'h1);
    chk("R11 queue 7 on user 0", {28'd0, irq}, 32'h1);
    wr(ad(3, 0), 32'h33);
    chk("R11 OR of lines", {28'd0, irq}, 32'h5);
    wr(ad(9, 0), 32'h99);
    rd_chk("R2 q3 word", ad(3, 0), 32'h33);
    chk("R11 other queue holds line", {28'd0, irq}, 32'h5);
    rd_chk("R2 q9 word", ad(9, 0), 32'h99);
    rd_chk("R2 q7 word", ad(7, 0), 32'h77);
    chk("R11 all lines low", {28'd0, irq}, 32'h0);

    // R10 three masters in the same cycle
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      req[m] = 1'b1; we[m] = 1'b1;
      addr[m*AW +: AW] = ad(5, 0);
      wdata[m*32 +: 32] = 32'hC0 + m;
    end
    #1 chk("R10 master 0 first", {29'd0, gnt}, 32'h1);
    @(negedge clk); req[0] = 1'b0;
    #1 chk("R10 master 1 second", {29'd0, gnt}, 32'h2);
    @(negedge clk); req[1] = 1'b0;
    #1 chk("R10 master 2 last", {29'd0, gnt}, 32'h4);
    @(negedge clk); req[2] = 1'b0;
    for (int m = 0; m < NM; m++)
      rd_chk("R10 priority order in queue", ad(5, 0), 32'hC0 + m);

    // R10 read on master 1 beats write on master 2
    @(negedge clk);
    req[1] = 1'b1; we[1] = 1'b0; addr[1*AW +: AW] = ad(5, 1);
    req[2] = 1'b1; we[2] = 1'b1; addr[2*AW +: AW] = ad(5, 0); wdata[64 +: 32] = 32'hEE;
    #1 chk("R10 lower index wins", {29'd0, gnt}, 32'h2);
    @(negedge clk); req[1] = 1'b0;
    chk("R10 read saw empty queue", rdata, 32'h1);
    #1 chk("R10 held request granted", {29'd0, gnt}, 32'h4);
    @(negedge clk); req[2] = 1'b0;
    rd_chk("R10 waiting write landed", ad(5, 0), 32'hEE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule